// File: doc/BRIEF.md
# Quad-SPI Flash Read Engine

This block lets a memory-mapped master fetch 32-bit words from a serial NOR flash. Each fetch runs one chip-select frame: an opcode phase, an address phase, a run of dummy clocks with the lines released, and a data phase. The engine then packs the sampled bits into one word. The lane count of each phase, the opcode, the dummy count and the address length all come from a small write-only configuration port. The same port can also launch a stand-alone one-byte command, for example the one that puts the flash into 4-byte addressing.

The master holds `rd_req` with an address and waits while `rd_wait` is high. In the cycle where `rd_wait` drops, the frame has already closed and `rd_valid` qualifies `rd_data`. The flash data lines are split into output, output-enable and input vectors. The pad ring joins them into bidirectional pins.

Top module: `qspi_read_engine`

## Requirements
- R1: After reset `cs_n` is high, `sck` is low, `dq_oe` is 0, `rd_wait` is high and `rd_valid` is low. Whenever `cs_n` is high, `sck` is low and `dq_oe` is 0.
- R2: The opcode (bits [7:0] of the read instruction register at offset 0x14) is sent MSB first. It takes 8/L SCK cycles, where L is the lane count set by protocol register (offset 0x10) bits [3:0]. The lane codes are 0 for one line on DQ0, 1 for two lines on DQ1:0 and 2 for four lines on DQ3:0.
- R3: The address goes out MSB first on the lanes set by protocol bits [7:4]. It is 32 bits when control register (offset 0x00) bit 8 is 1. Otherwise it is the low 24 bits.
- R4: After the address, the engine gives exactly N dummy SCK cycles, where N is read instruction bits [11:8]. N = 0 skips the phase. All four lines are released (`dq_oe` = 0) from the first dummy cycle to the end of the frame.
- R5: The data phase lasts 32/L SCK cycles on the lanes set by protocol bits [11:8]. Input is sampled at the rising SCK edge, from DQ1 in single-line mode. The first byte received becomes bits [7:0] of `rd_data`, so flash bytes 21 43 65 87 give 0x87654321.
- R6: `rd_wait` stays high from the request until `cs_n` has gone high. In the single cycle where it drops, `rd_valid` is high with the assembled word on `rd_data`.
- R7: Writing an opcode to offset 0x1C, then writing offset 0x20 with bit 0 set, sends one frame that holds only that opcode (8/L cycles, lanes from protocol bits [3:0]). A write to 0x20 with bit 0 clear starts nothing.
- R8: SCK is mode 0. With divider D (offset 0x04, where 0 counts as 1), each SCK half-period is D clock cycles. Outputs change only at falling SCK edges.
- R9: CS delay register (offset 0x08) bits [3:0] give S setup clocks and bits [7:4] give H hold clocks. A frame with C SCK cycles keeps `cs_n` low for exactly S + 2·D·C + H clock cycles.
- R10: A read request that arrives while a command is pending or running is held, with `rd_wait` high, and is served once that command frame ends.
- R11: The reset configuration is divider 1, no CS delays, protocol 0x220, read instruction 0xAEB and 24-bit addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| rd_req | input | 1 | Word read request |
| rd_addr | input | 32 | Flash byte address |
| rd_wait | output | 1 | Stall; low in the completion cycle |
| rd_valid | output | 1 | Read data qualifier |
| rd_data | output | 32 | Assembled word |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Data line output values |
| dq_oe | output | 4 | Data line output enables |
| dq_in | input | 4 | Data line input values |

## Verification
The embedded properties check the cycle-level invariants on every clock. These are the idle state of SCK and the data lines while deselected, outputs held steady across each rising SCK edge, and the completion cycle being a single pulse with chip select already high. A behavioural flash in the bench is needed for the rest: per-phase cycle counts, the release of the lines before the flash drives, the opcode and address bits the flash actually received, the byte order of the returned word, and frame length against divider and CS delays. The bench sweeps dividers, lane mixes, dummy counts and address lengths to cover these.

// File: rtl/qspi_read_engine.sv
module qspi_read_engine #(
  parameter int DIVW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        rd_req,
  input  logic [31:0] rd_addr,
  output logic        rd_wait,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  dq_out,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_in
);

  localparam logic [DIVW-1:0] ONE = DIVW'(1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_OP, S_ADDR, S_DUMMY, S_DATA, S_HOLD, S_FIN} st_t;

  st_t              st;
  logic             a4;
  logic [DIVW-1:0]  div_r, tcnt, dv;
  logic [3:0]       setup_r, hold_r, dmy_r, dcnt;
  logic [1:0]       pw_i, pw_a, pw_d, lg;
  logic [7:0]       rd_op, cmd_op;
  logic             cmd_pend, is_rd, in_sck, tick;
  logic [5:0]       cnt, op_cyc, ad_cyc, dt_cyc;
  logic [31:0]      sh, sh_nx, rx, rx_nx, addr_l;
  logic             cfg_unused;

  assign cfg_unused = ^cfg_wdata[31:12];

  function automatic logic [1:0] lgof(input logic [1:0] c);
    return (c == 2'd0) ? 2'd0 : (c == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a4 <= 1'b0; div_r <= ONE; setup_r <= '0; hold_r <= '0;
      pw_i <= 2'd0; pw_a <= 2'd2; pw_d <= 2'd2;
      rd_op <= 8'hEB; dmy_r <= 4'd10; cmd_op <= 8'h00;
    end else if (cfg_we) begin
      case (cfg_addr)
        6'h00: a4 <= cfg_wdata[8];
        6'h04: div_r <= cfg_wdata[DIVW-1:0];
        6'h08: begin setup_r <= cfg_wdata[3:0]; hold_r <= cfg_wdata[7:4]; end
        6'h10: begin pw_i <= cfg_wdata[1:0]; pw_a <= cfg_wdata[5:4]; pw_d <= cfg_wdata[9:8]; end
        6'h14: begin rd_op <= cfg_wdata[7:0]; dmy_r <= cfg_wdata[11:8]; end
        6'h1C: cmd_op <= cfg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_OP:    lg = lgof(pw_i);
      S_ADDR:  lg = lgof(pw_a);
      default: lg = lgof(pw_d);
    endcase
  end

  assign op_cyc = 6'd8 >> lgof(pw_i);
  assign ad_cyc = (a4 ? 6'd32 : 6'd24) >> lgof(pw_a);
  assign dt_cyc = 6'd32 >> lgof(pw_d);
  assign dv     = (div_r == '0) ? ONE : div_r;
  assign in_sck = (st == S_OP) || (st == S_ADDR) || (st == S_DUMMY) || (st == S_DATA);
  assign tick   = in_sck && (tcnt == dv - ONE);

  always_comb begin
    case (lg)
      2'd0: begin sh_nx = {sh[30:0], 1'b0};  rx_nx = {rx[30:0], dq_in[1]};   dq_out = {3'b0, sh[31]};    end
      2'd1: begin sh_nx = {sh[29:0], 2'b0};  rx_nx = {rx[29:0], dq_in[1:0]}; dq_out = {2'b0, sh[31:30]}; end
      default: begin sh_nx = {sh[27:0], 4'b0}; rx_nx = {rx[27:0], dq_in};  dq_out = sh[31:28];          end
    endcase
  end

  assign dq_oe    = (st == S_OP || st == S_ADDR) ? ((lg == 2'd0) ? 4'b0001 : (lg == 2'd1) ? 4'b0011 : 4'b1111) : 4'b0000;
  assign rd_valid = (st == S_FIN) && is_rd;
  assign rd_wait  = !rd_valid;
  assign rd_data  = {rx[7:0], rx[15:8], rx[23:16], rx[31:24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_n <= 1'b1; sck <= 1'b0; tcnt <= '0; cnt <= '0; dcnt <= '0;
      sh <= '0; rx <= '0; addr_l <= '0; is_rd <= 1'b0; cmd_pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_pend || rd_req) begin
          is_rd  <= !cmd_pend;
          sh     <= {cmd_pend ? cmd_op : rd_op, 24'h0};
          if (!cmd_pend) addr_l <= rd_addr;
          cmd_pend <= 1'b0;
          cs_n <= 1'b0; sck <= 1'b0; tcnt <= '0; cnt <= op_cyc; dcnt <= setup_r;
          st   <= (setup_r != 4'd0) ? S_SETUP : S_OP;
        end
        S_SETUP: if (dcnt == 4'd1) st <= S_OP; else dcnt <= dcnt - 4'd1;
        S_HOLD:  if (dcnt == 4'd1) begin cs_n <= 1'b1; st <= S_FIN; end else dcnt <= dcnt - 4'd1;
        S_FIN:   st <= S_IDLE;
        default: if (!tick) tcnt <= tcnt + ONE;
        else begin
          tcnt <= '0;
          sck  <= ~sck;
          if (!sck) begin
            if (st == S_DATA) rx <= rx_nx;
          end else begin
            sh <= sh_nx;
            if (cnt != 6'd1) cnt <= cnt - 6'd1;
            else if (st == S_OP && is_rd) begin
              st <= S_ADDR; cnt <= ad_cyc;
              sh <= a4 ? addr_l : {addr_l[23:0], 8'h0};
            end else if (st == S_ADDR && dmy_r != 4'd0) begin
              st <= S_DUMMY; cnt <= {2'b0, dmy_r};
            end else if (st == S_ADDR || st == S_DUMMY) begin
              st <= S_DATA; cnt <= dt_cyc;
            end else if (hold_r != 4'd0) begin
              st <= S_HOLD; dcnt <= hold_r;
            end else begin
              st <= S_FIN; cs_n <= 1'b1;
            end
          end
        end
      endcase
      if (cfg_we && cfg_addr == 6'h20 && cfg_wdata[0]) cmd_pend <= 1'b1;
    end
  end

  // R1
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (dq_oe == 4'b0000));
  // R6
  valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (cs_n && !rd_wait));
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid);
  // R8
  mode0_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> ($stable(dq_out) && $stable(dq_oe)));

endmodule

// File: tb/qspi_read_engine_tb.sv
module qspi_read_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 1'b0, rd_req = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, rd_addr = '0;
  logic        rd_wait, rd_valid, sck, cs_n;
  logic [31:0] rd_data;
  logic [3:0]  dq_out, dq_oe, dq_in, fdq = 4'h0;
  logic        foe = 1'b0;

  qspi_read_engine u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_wait(rd_wait),
    .rd_valid(rd_valid), .rd_data(rd_data), .sck(sck), .cs_n(cs_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in));

  assign dq_in = (foe && !cs_n) ? fdq : 4'h0;

  int n_chk = 0, n_fail = 0;
  int il = 1, al = 4, dl = 4, nd = 10, ab = 3, dd = 1, ss = 0, hh = 0;
  logic [7:0] rop = 8'hEB;
  int rc = 0, oe_err = 0, n_tx = 0, last_rc = 0, lowc = 0;
  logic [31:0] op_cap = '0, ad_cap = '0, last_op = '0, last_ad = '0;
  logic prev_cs = 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [3:0] lmask(input int l);
    return (l == 1) ? 4'b0001 : (l == 2) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [7:0] fb(input logic [31:0] a);
    case (a)
      32'd0: return 8'h21;
      32'd1: return 8'h43;
      32'd2: return 8'h65;
      32'd3: return 8'h87;
      default: return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'hC3;
    endcase
  endfunction

  // behavioural flash: capture on rising SCK, drive on falling SCK
  always @(posedge sck or negedge cs_n) begin
    if (!sck) begin
      rc = 0; op_cap = '0; ad_cap = '0;
    end else begin
      int opc, adc;
      opc = 8 / il; adc = ab * 8 / al;
      if (rc < opc) begin
        op_cap = (op_cap << il) | ((il == 1) ? 32'(dq_out[0]) : (il == 2) ? 32'(dq_out[1:0]) : 32'(dq_out));
        if (dq_oe != lmask(il)) oe_err++;
      end else if (rc < opc + adc) begin
        ad_cap = (ad_cap << al) | ((al == 1) ? 32'(dq_out[0]) : (al == 2) ? 32'(dq_out[1:0]) : 32'(dq_out));
        if (dq_oe != lmask(al)) oe_err++;
      end else if (dq_oe != 4'h0) oe_err++;
      rc++;
    end
  end

  always @(negedge sck) begin
    int base;
    logic [31:0] s;
    base = 8 / il + ab * 8 / al + nd;
    if (!cs_n && rc >= base && rc < base + 32 / dl) begin
      s = {fb(ad_cap), fb(ad_cap + 1), fb(ad_cap + 2), fb(ad_cap + 3)} << ((rc - base) * dl);
      fdq = (dl == 4) ? s[31:28] : (dl == 2) ? {2'b0, s[31:30]} : {2'b0, s[31], 1'b0};
      foe = 1'b1;
    end else foe = 1'b0;
  end

  always @(posedge cs_n) begin
    last_op = op_cap; last_ad = ad_cap; last_rc = rc; n_tx++;
  end

  always @(posedge clk) begin
    prev_cs <= cs_n;
    if (!cs_n) lowc <= prev_cs ? 1 : lowc + 1;
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic cw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output bit v, output bit hs);
    @(negedge clk); rd_req = 1'b1; rd_addr = a;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!rd_wait) break;
    end
    d = rd_data; v = rd_valid; hs = cs_n && !rd_wait;
    rd_req = 1'b0;
    @(negedge clk);
    v = v && !rd_valid;
  endtask

  task automatic run_read(input logic [31:0] a);
    logic [31:0] ea, d, ew;
    bit v, hs;
    int c, e0;
    e0 = oe_err;
    ea = (ab == 4) ? a : (a & 32'h00FF_FFFF);
    c  = 8 / il + ab * 8 / al + nd + 32 / dl;
    ew = {fb(ea + 3), fb(ea + 2), fb(ea + 1), fb(ea)};
    do_read(a, d, v, hs);
    chk(v && hs, "R6 handshake", {v, hs}, 2'b11);
    chk(d == ew, "R5 data word", d, ew);
    chk(last_op == 32'(rop), "R2 opcode", last_op, rop);
    chk(last_ad == ea, "R3 address", last_ad, ea);
    chk(oe_err == e0, "R4 turnaround", oe_err - e0, 0);
    chk(last_rc == c, "R4 sck cycles", last_rc, c);
    chk(lowc == ss + 2 * dd * c + hh, "R9 cs low time", lowc, ss + 2 * dd * c + hh);
  endtask

  task automatic setup_cfg(input int div, input int s, input int h, input int ic, input int ac,
                           input int dc, input int n, input int abytes, input logic [7:0] op);
    cw(6'h04, 32'(div)); cw(6'h08, 32'((h << 4) | s));
    cw(6'h10, 32'((dc << 8) | (ac << 4) | ic));
    cw(6'h14, 32'((n << 8) | op)); cw(6'h00, (abytes == 4) ? 32'h100 : 32'h0);
    dd = (div == 0) ? 1 : div; ss = s; hh = h; il = 1 << ic; al = 1 << ac; dl = 1 << dc;
    nd = n; ab = abytes; rop = op;
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && !sck && dq_oe == 0 && rd_wait && !rd_valid, "R1 reset outputs",
        {cs_n, sck, dq_oe, rd_wait, rd_valid}, 8'b1_0_0000_1_0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 command frame with reset config (R11)
    t0 = n_tx;
    cw(6'h1C, 32'hB7); cw(6'h20, 32'h1);
    repeat (40) @(negedge clk);
    chk(n_tx == t0 + 1 && last_op == 32'hB7, "R7 command opcode", last_op, 32'hB7);
    chk(last_rc == 8 && lowc == 16, "R7 command length", {last_rc[7:0], lowc[7:0]}, 16'h0810);

    // R7 trigger with bit0 clear does nothing
    t0 = n_tx;
    cw(6'h20, 32'h2);
    repeat (60) @(negedge clk);
    chk(n_tx == t0 && cs_n, "R7 ignored trigger", n_tx - t0, 0);

    // R11 default read: 3-byte addr, quad addr/data, 10 dummies
    run_read(32'h0);
    chk(rd_data == 32'h8765_4321, "R11 default read word", rd_data, 32'h8765_4321);

    // R10 read queued behind a pending command
    cw(6'h00, 32'h101); ab = 4;
    t0 = n_tx;
    cw(6'h20, 32'h1);
    run_read(32'h0000_0010);
    chk(n_tx == t0 + 2, "R10 command then read", n_tx - t0, 2);

    // sweep divider and lane mixes (R2 R3 R4 R5 R8 R9)
    for (int di = 0; di <= 3; di++) begin
      for (int k = 0; k < 5; k++) begin
        case (k)
          0: setup_cfg(di, 0, 0, 0, 2, 2, 10, 4, 8'hEB);
          1: setup_cfg(di, 0, 0, 0, 0, 0, 8, 4, 8'h0C);
          2: setup_cfg(di, 2, 3, 0, 1, 1, 4, 3, 8'hBB);
          3: setup_cfg(di, 1, 0, 2, 2, 2, 0, 4, 8'hEC);
          default: setup_cfg(di, 0, 2, 1, 1, 2, 6, 3, 8'h6B);
        endcase
        for (int j = 0; j < 3; j++)
          run_read((j == 0) ? 32'h0 : (j == 1) ? 32'h0123_4568 + 32'(k * 77) : 32'hFFFF_FFFC);
      end
    end
    finish_up();
  end
endmodule